// File: doc/BRIEF.md
# Machine-Check Error Bank Injector

This block holds a small array of machine-check error banks. Each bank has four 64-bit words: a control word, a status word, an address word and a miscellaneous word. Three global registers sit beside the banks: a read-only capability word, a global control word and a global status word. An error source presents an injection request that names a bank and carries a status, a global status, an address and a miscellaneous value. In the cycle the request is presented, the block decides whether to ignore it, record it, mark an overflow, raise a machine-check interrupt, or ask for a system reset because an uncorrected error has arrived while another is still being handled.

After reset a walk runs for one cycle per bank. If the configured processor family is 6 or higher and both machine-check feature inputs are set, the walk loads the default capability, sets the global control to all ones and sets every bank control word to all ones. Otherwise these registers stay zero, so the bank count is zero and every request is ignored. Software sees all words through a word-addressed register port. It clears the in-progress flag by writing the global status word.

Top module: `mcb_injector`

## Requirements
- R1: `init_busy` is high during reset and for exactly MAX_BANKS rising edges after reset is released. While it is high, injection requests and register writes have no effect. `mce_irq` and `reset_req` are low during reset.
- R2: If `cfg_family` >= 6 and both `cfg_mce_feat` and `cfg_mca_feat` are set, the walk leaves these values: capability = bit 8 set plus DEF_BANKS in bits 7:0, global control = all ones, every bank control = all ones. All other words are zero. With any of these conditions missing, every word reads zero.
- R3: A request whose bank index is not below the capability count (bits 7:0), or not below MAX_BANKS, changes no word and produces no pulse.
- R4: A request whose status bit 63 (valid) is clear changes no word and produces no pulse.
- R5: An uncorrected request (status bit 61 set) is dropped with no pulse when capability bit 8 is set and the global control is not all ones.
- R6: An uncorrected request is dropped with no pulse when the target bank's control word is not all ones.
- R7: An uncorrected request that passes R3 to R6 while global status bit 2 (in progress) is set or `mce_en` is low records nothing. It pulses `reset_req` high for one cycle, in the cycle after the request.
- R8: Otherwise an uncorrected request writes the bank's status, address and miscellaneous words and the global status. If the bank status was already valid, bit 62 (overflow) is set in the written status. `mce_irq` pulses high for one cycle, in the cycle after the request.
- R9: A corrected request (bit 61 clear) to a bank that is empty or holds a corrected error writes the status (with bit 62 set if the bank was valid), the address and the miscellaneous words. It leaves the global status alone and raises no pulse.
- R10: A corrected request to a bank holding a valid uncorrected error only sets bit 62 of the existing status. The address and miscellaneous words are unchanged.
- R11: Register word 4*b+0/1/2/3 is bank b control/status/address/miscellaneous. Word 4*MAX_BANKS+0/1/2 is capability/global control/global status. Capability ignores writes. Unmapped words read zero. Reads are combinational, and writes take effect on the next edge.
- R12: A register write in the same cycle as an injection request (`inj_valid` high) is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_family | input | 4 | Processor family used by the reset walk |
| cfg_mce_feat | input | 1 | Machine-check exception feature present |
| cfg_mca_feat | input | 1 | Machine-check architecture feature present |
| mce_en | input | 1 | Machine-check enable from processor control |
| inj_valid | input | 1 | Injection request strobe |
| inj_bank | input | 8 | Target bank index |
| inj_status | input | 64 | Bank status value (63 valid, 62 overflow, 61 uncorrected) |
| inj_gstatus | input | 64 | Global status value (bit 2 in progress) |
| inj_addr | input | 64 | Error address word |
| inj_misc | input | 64 | Miscellaneous word |
| reg_addr | input | AW (5) | Word index for the register port |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr` |
| init_busy | output | 1 | Reset walk in progress |
| mce_irq | output | 1 | Machine-check interrupt pulse |
| reset_req | output | 1 | System reset request pulse |

## Verification
The bench targets these corner cases:
- Uncorrected errors nested behind the in-progress flag, and uncorrected errors arriving with `mce_en` low. A design that recorded these would overwrite the first error's log instead of escalating to `reset_req`.
- A corrected error landing on a pending uncorrected entry. A design that got this wrong would lose the uncorrected address.
- Overflow marking on a second error. A wrong design would set or omit bit 62 at the wrong time.
- Bank indices at or above the count, and gating by control words that are almost all ones. A design that compared only a few bits would accept errors it must drop.
- Requests and writes during the reset walk, and same-cycle write-versus-inject collisions. These would show up as stray words in the register map.

// File: rtl/mcb_pkg.sv
package mcb_pkg;

    localparam int WORD_W     = 64;
    localparam int STS_VAL    = 63;
    localparam int STS_OVER   = 62;
    localparam int STS_UC     = 61;
    localparam int CAP_CTLP   = 8;
    localparam int GST_INPROG = 2;
    localparam int MIN_FAMILY = 6;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t ctl;
        word_t sts;
        word_t adr;
        word_t misc;
    } bank_t;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_DROP,
        ACT_RESET,
        ACT_UC_WRITE,
        ACT_CE_WRITE,
        ACT_CE_MARK
    } act_e;

    typedef enum logic {
        SEQ_WALK,
        SEQ_DONE
    } seq_e;

    typedef struct packed {
        logic       vld;
        logic [7:0] bank;
        word_t      sts;
    } req_t;

    typedef struct packed {
        act_e       kind;
        logic [7:0] bank;
        word_t      sts;
    } dec_t;

    function automatic word_t with_over(word_t s, logic prior);
        return prior ? (s | (word_t'(1) << STS_OVER)) : s;
    endfunction

    function automatic logic is_all_ones(word_t w);
        return &w;
    endfunction

    function automatic word_t cap_default(int banks);
        return word_t'(banks) | (word_t'(1) << CAP_CTLP);
    endfunction

endpackage

// File: rtl/mcb_init_seq.sv
module mcb_init_seq
    import mcb_pkg::*;
#(
    parameter int MAX_BANKS = 4,
    localparam int IW = (MAX_BANKS > 1) ? $clog2(MAX_BANKS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    cfg_family,
    input  logic          cfg_mce_feat,
    input  logic          cfg_mca_feat,
    output logic          busy,
    output logic          first,
    output logic          qual,
    output logic [IW-1:0] idx
);

    seq_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_WALK;
            idx     <= '0;
        end else if (state_q == SEQ_WALK) begin
            if (idx == IW'(MAX_BANKS - 1)) begin
                state_q <= SEQ_DONE;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    assign busy  = (state_q == SEQ_WALK);
    assign first = busy && (idx == '0);
    assign qual  = (cfg_family >= 4'(MIN_FAMILY)) && cfg_mce_feat && cfg_mca_feat;

endmodule

// File: rtl/mcb_decide.sv
module mcb_decide
    import mcb_pkg::*;
#(
    parameter int MAX_BANKS = 4
) (
    input  req_t                  req,
    input  logic [7:0]            cap_cnt,
    input  logic                  cap_ctlp,
    input  word_t                 gctl,
    input  logic                  gsts_inprog,
    input  logic                  mce_en,
    input  word_t [MAX_BANKS-1:0] ctl_v,
    input  word_t [MAX_BANKS-1:0] sts_v,
    output dec_t                  dec
);

    logic  hit;
    word_t sel_ctl;
    word_t sel_sts;

    always_comb begin
        hit     = 1'b0;
        sel_ctl = '0;
        sel_sts = '0;
        for (int i = 0; i < MAX_BANKS; i++) begin
            if (req.bank == 8'(i)) begin
                hit     = 1'b1;
                sel_ctl = ctl_v[i];
                sel_sts = sts_v[i];
            end
        end
    end

    always_comb begin
        dec.bank = req.bank;
        dec.sts  = req.sts;
        dec.kind = ACT_NONE;
        if (req.vld) begin
            if (!hit || (req.bank >= cap_cnt) || !req.sts[STS_VAL]) begin
                dec.kind = ACT_DROP;
            end else if (req.sts[STS_UC]) begin
                if (cap_ctlp && !is_all_ones(gctl)) begin
                    dec.kind = ACT_DROP;
                end else if (!is_all_ones(sel_ctl)) begin
                    dec.kind = ACT_DROP;
                end else if (gsts_inprog || !mce_en) begin
                    dec.kind = ACT_RESET;
                end else begin
                    dec.kind = ACT_UC_WRITE;
                    dec.sts  = with_over(req.sts, sel_sts[STS_VAL]);
                end
            end else if (!sel_sts[STS_VAL] || !sel_sts[STS_UC]) begin
                dec.kind = ACT_CE_WRITE;
                dec.sts  = with_over(req.sts, sel_sts[STS_VAL]);
            end else begin
                dec.kind = ACT_CE_MARK;
                dec.sts  = sel_sts | (word_t'(1) << STS_OVER);
            end
        end
    end

endmodule

// File: rtl/mcb_store.sv
module mcb_store
    import mcb_pkg::*;
#(
    parameter int MAX_BANKS = 4,
    parameter int DEF_BANKS = 4,
    localparam int NWORDS = 4 * MAX_BANKS + 3,
    localparam int AW = $clog2(NWORDS),
    localparam int IW = (MAX_BANKS > 1) ? $clog2(MAX_BANKS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  init_busy,
    input  logic                  init_first,
    input  logic                  init_qual,
    input  logic [IW-1:0]         init_idx,
    input  dec_t                  dec,
    input  word_t                 inj_gstatus,
    input  word_t                 inj_addr,
    input  word_t                 inj_misc,
    input  logic                  wr_ok,
    input  logic [AW-1:0]         reg_addr,
    input  word_t                 reg_wdata,
    output word_t                 reg_rdata,
    output word_t [MAX_BANKS-1:0] ctl_v,
    output word_t [MAX_BANKS-1:0] sts_v,
    output word_t                 cap_q,
    output word_t                 gctl_q,
    output word_t                 gsts_q,
    output logic                  irq_q,
    output logic                  rreq_q
);

    localparam int A_CAP  = 4 * MAX_BANKS;
    localparam int A_GCTL = 4 * MAX_BANKS + 1;
    localparam int A_GSTS = 4 * MAX_BANKS + 2;

    word_t flat [4*MAX_BANKS];

    for (genvar b = 0; b < MAX_BANKS; b++) begin : g_bank
        bank_t q;
        logic  act_hit;

        assign act_hit = (dec.bank == 8'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (init_busy) begin
                if (init_idx == IW'(b)) begin
                    q.ctl <= init_qual ? '1 : '0;
                end
            end else if (act_hit && (dec.kind == ACT_UC_WRITE || dec.kind == ACT_CE_WRITE)) begin
                q.sts  <= dec.sts;
                q.adr  <= inj_addr;
                q.misc <= inj_misc;
            end else if (act_hit && dec.kind == ACT_CE_MARK) begin
                q.sts <= dec.sts;
            end else if (wr_ok) begin
                if (reg_addr == AW'(4*b + 0)) q.ctl  <= reg_wdata;
                if (reg_addr == AW'(4*b + 1)) q.sts  <= reg_wdata;
                if (reg_addr == AW'(4*b + 2)) q.adr  <= reg_wdata;
                if (reg_addr == AW'(4*b + 3)) q.misc <= reg_wdata;
            end
        end

        assign ctl_v[b]      = q.ctl;
        assign sts_v[b]      = q.sts;
        assign flat[4*b + 0] = q.ctl;
        assign flat[4*b + 1] = q.sts;
        assign flat[4*b + 2] = q.adr;
        assign flat[4*b + 3] = q.misc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q  <= '0;
            gctl_q <= '0;
            gsts_q <= '0;
            irq_q  <= 1'b0;
            rreq_q <= 1'b0;
        end else begin
            irq_q  <= (dec.kind == ACT_UC_WRITE);
            rreq_q <= (dec.kind == ACT_RESET);
            if (init_first) begin
                cap_q  <= init_qual ? cap_default(DEF_BANKS) : '0;
                gctl_q <= init_qual ? '1 : '0;
            end else if (wr_ok && reg_addr == AW'(A_GCTL)) begin
                gctl_q <= reg_wdata;
            end
            if (dec.kind == ACT_UC_WRITE) begin
                gsts_q <= inj_gstatus;
            end else if (wr_ok && reg_addr == AW'(A_GSTS)) begin
                gsts_q <= reg_wdata;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < 4 * MAX_BANKS; i++) begin
            if (reg_addr == AW'(i)) reg_rdata = flat[i];
        end
        if (reg_addr == AW'(A_CAP))  reg_rdata = cap_q;
        if (reg_addr == AW'(A_GCTL)) reg_rdata = gctl_q;
        if (reg_addr == AW'(A_GSTS)) reg_rdata = gsts_q;
    end

endmodule

// File: rtl/mcb_injector.sv
module mcb_injector
    import mcb_pkg::*;
#(
    parameter int MAX_BANKS = 4,
    parameter int DEF_BANKS = 4,
    localparam int NWORDS = 4 * MAX_BANKS + 3,
    localparam int AW = $clog2(NWORDS),
    localparam int IW = (MAX_BANKS > 1) ? $clog2(MAX_BANKS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    cfg_family,
    input  logic          cfg_mce_feat,
    input  logic          cfg_mca_feat,
    input  logic          mce_en,
    input  logic          inj_valid,
    input  logic [7:0]    inj_bank,
    input  logic [63:0]   inj_status,
    input  logic [63:0]   inj_gstatus,
    input  logic [63:0]   inj_addr,
    input  logic [63:0]   inj_misc,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic [63:0]   reg_wdata,
    output logic [63:0]   reg_rdata,
    output logic          init_busy,
    output logic          mce_irq,
    output logic          reset_req
);

    logic                  init_first;
    logic                  init_qual;
    logic [IW-1:0]         init_idx;
    logic                  wr_ok;
    req_t                  req;
    dec_t                  dec;
    word_t [MAX_BANKS-1:0] ctl_v;
    word_t [MAX_BANKS-1:0] sts_v;
    word_t                 cap_q;
    word_t                 gctl_q;
    word_t                 gsts_q;

    assign req.vld  = inj_valid && !init_busy;
    assign req.bank = inj_bank;
    assign req.sts  = inj_status;
    assign wr_ok    = reg_wr && !init_busy && !inj_valid;

    mcb_init_seq #(.MAX_BANKS(MAX_BANKS)) u_init (
        .clk          (clk),
        .rst          (rst),
        .cfg_family   (cfg_family),
        .cfg_mce_feat (cfg_mce_feat),
        .cfg_mca_feat (cfg_mca_feat),
        .busy         (init_busy),
        .first        (init_first),
        .qual         (init_qual),
        .idx          (init_idx)
    );

    mcb_decide #(.MAX_BANKS(MAX_BANKS)) u_decide (
        .req         (req),
        .cap_cnt     (cap_q[7:0]),
        .cap_ctlp    (cap_q[CAP_CTLP]),
        .gctl        (gctl_q),
        .gsts_inprog (gsts_q[GST_INPROG]),
        .mce_en      (mce_en),
        .ctl_v       (ctl_v),
        .sts_v       (sts_v),
        .dec         (dec)
    );

    mcb_store #(.MAX_BANKS(MAX_BANKS), .DEF_BANKS(DEF_BANKS)) u_store (
        .clk         (clk),
        .rst         (rst),
        .init_busy   (init_busy),
        .init_first  (init_first),
        .init_qual   (init_qual),
        .init_idx    (init_idx),
        .dec         (dec),
        .inj_gstatus (inj_gstatus),
        .inj_addr    (inj_addr),
        .inj_misc    (inj_misc),
        .wr_ok       (wr_ok),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .ctl_v       (ctl_v),
        .sts_v       (sts_v),
        .cap_q       (cap_q),
        .gctl_q      (gctl_q),
        .gsts_q      (gsts_q),
        .irq_q       (mce_irq),
        .rreq_q      (reset_req)
    );

endmodule

// File: rtl/mcb_injector_chk.sv
module mcb_injector_chk (
    input logic        clk,
    input logic        rst,
    input logic        init_busy,
    input logic        inj_valid,
    input logic        inj_val_bit,
    input logic        inj_uc_bit,
    input logic [63:0] inj_gstatus,
    input logic        mce_en,
    input logic [63:0] gsts,
    input logic        mce_irq,
    input logic        reset_req
);

    p_walk_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        init_busy |=> (!mce_irq && !reset_req));

    p_invalid_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (inj_valid && !inj_val_bit) |=> (!mce_irq && !reset_req));

    p_reset_cause_r7: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> $past(inj_valid && !init_busy && inj_uc_bit && (!mce_en || gsts[2])));

    p_not_both_r7: assert property (@(posedge clk) disable iff (rst)
        !(mce_irq && reset_req));

    p_irq_cause_r8: assert property (@(posedge clk) disable iff (rst)
        mce_irq |-> $past(inj_valid && !init_busy && inj_val_bit && inj_uc_bit && mce_en && !gsts[2]));

    p_irq_gsts_r8: assert property (@(posedge clk) disable iff (rst)
        mce_irq |-> (gsts == $past(inj_gstatus)));

endmodule

bind mcb_injector mcb_injector_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .init_busy   (init_busy),
    .inj_valid   (inj_valid),
    .inj_val_bit (inj_status[63]),
    .inj_uc_bit  (inj_status[61]),
    .inj_gstatus (inj_gstatus),
    .mce_en      (mce_en),
    .gsts        (gsts_q),
    .mce_irq     (mce_irq),
    .reset_req   (reset_req)
);

// File: tb/tb_mcb_injector.sv
module tb_mcb_injector;

    localparam int NB   = 4;
    localparam int AW   = 5;
    localparam int A_CAP  = 4 * NB;
    localparam int A_GCTL = 4 * NB + 1;
    localparam int A_GSTS = 4 * NB + 2;
    localparam logic [63:0] ONES = '1;
    localparam logic [63:0] VAL  = 64'h8000_0000_0000_0000;
    localparam logic [63:0] OVR  = 64'h4000_0000_0000_0000;
    localparam logic [63:0] UC   = 64'h2000_0000_0000_0000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    cfg_family = 4'd6;
    logic          cfg_mce_feat = 1'b1;
    logic          cfg_mca_feat = 1'b1;
    logic          mce_en = 1'b1;
    logic          inj_valid = 1'b0;
    logic [7:0]    inj_bank = '0;
    logic [63:0]   inj_status = '0;
    logic [63:0]   inj_gstatus = '0;
    logic [63:0]   inj_addr = '0;
    logic [63:0]   inj_misc = '0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [63:0]   reg_wdata = '0;
    logic [63:0]   reg_rdata;
    logic          init_busy;
    logic          mce_irq;
    logic          reset_req;

    int n_chk = 0;
    int n_err = 0;

    logic [63:0] m_ctl [NB];
    logic [63:0] m_sts [NB];
    logic [63:0] m_adr [NB];
    logic [63:0] m_misc [NB];
    logic [63:0] m_cap, m_gctl, m_gsts;
    logic        e_irq, e_rr;

    always #10 clk = ~clk;

    mcb_injector dut (
        .clk(clk), .rst(rst), .cfg_family(cfg_family), .cfg_mce_feat(cfg_mce_feat),
        .cfg_mca_feat(cfg_mca_feat), .mce_en(mce_en), .inj_valid(inj_valid),
        .inj_bank(inj_bank), .inj_status(inj_status), .inj_gstatus(inj_gstatus),
        .inj_addr(inj_addr), .inj_misc(inj_misc), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .init_busy(init_busy),
        .mce_irq(mce_irq), .reset_req(reset_req)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [63:0] v);
        reg_addr = AW'(a);
        #1;
        v = reg_rdata;
    endtask

    task automatic chk_word(input int a, input logic [63:0] exp, input string tag);
        logic [63:0] v;
        rd(a, v);
        chk(v, exp, tag);
    endtask

    task automatic mdl_clear();
        for (int i = 0; i < NB; i++) begin
            m_ctl[i] = '0; m_sts[i] = '0; m_adr[i] = '0; m_misc[i] = '0;
        end
        m_cap = '0; m_gctl = '0; m_gsts = '0;
    endtask

    task automatic mdl_write(input int a, input logic [63:0] d);
        if (a < 4 * NB) begin
            case (a % 4)
                0: m_ctl[a/4] = d;
                1: m_sts[a/4] = d;
                2: m_adr[a/4] = d;
                default: m_misc[a/4] = d;
            endcase
        end else if (a == A_GCTL) m_gctl = d;
        else if (a == A_GSTS) m_gsts = d;
    endtask

    task automatic mdl_inject(input int b, input logic [63:0] s, input logic [63:0] g,
                              input logic [63:0] ad, input logic [63:0] mi, input logic en);
        logic prior;
        e_irq = 1'b0; e_rr = 1'b0;
        if (b >= int'(m_cap[7:0]) || b >= NB || !s[63]) return;
        prior = m_sts[b][63];
        if (s[61]) begin
            if (m_cap[8] && m_gctl != ONES) return;
            if (m_ctl[b] != ONES) return;
            if (m_gsts[2] || !en) begin e_rr = 1'b1; return; end
            m_sts[b] = prior ? (s | OVR) : s;
            m_adr[b] = ad; m_misc[b] = mi; m_gsts = g; e_irq = 1'b1;
        end else if (!prior || !m_sts[b][61]) begin
            m_sts[b] = prior ? (s | OVR) : s;
            m_adr[b] = ad; m_misc[b] = mi;
        end else begin
            m_sts[b] = m_sts[b] | OVR;
        end
    endtask

    task automatic verify_all(input string tag);
        for (int i = 0; i < NB; i++) begin
            chk_word(4*i + 0, m_ctl[i], tag);
            chk_word(4*i + 1, m_sts[i], tag);
            chk_word(4*i + 2, m_adr[i], tag);
            chk_word(4*i + 3, m_misc[i], tag);
        end
        chk_word(A_GCTL, m_gctl, tag);
        chk_word(A_GSTS, m_gsts, tag);
    endtask

    task automatic inject(input int b, input logic [63:0] s, input logic [63:0] g,
                          input logic [63:0] ad, input logic [63:0] mi, input string tag);
        inj_bank = 8'(b); inj_status = s; inj_gstatus = g;
        inj_addr = ad; inj_misc = mi; inj_valid = 1'b1;
        mdl_inject(b, s, g, ad, mi, mce_en);
        @(posedge clk);
        @(negedge clk);
        inj_valid = 1'b0;
        chk({63'd0, mce_irq}, {63'd0, e_irq}, {tag, " irq"});
        chk({63'd0, reset_req}, {63'd0, e_rr}, {tag, " reset_req"});
        if (b < NB) begin
            chk_word(4*b + 1, m_sts[b], {tag, " status"});
            chk_word(4*b + 2, m_adr[b], {tag, " addr"});
            chk_word(4*b + 3, m_misc[b], {tag, " misc"});
        end
        chk_word(A_GSTS, m_gsts, {tag, " gstatus"});
    endtask

    task automatic sw_write(input int a, input logic [63:0] d);
        reg_addr = AW'(a); reg_wdata = d; reg_wr = 1'b1;
        if (a != A_CAP) mdl_write(a, d);
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_reset(input logic [3:0] fam, input logic f1, input logic f2, input string tag);
        int n;
        cfg_family = fam; cfg_mce_feat = f1; cfg_mca_feat = f2;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: quiet outputs, walk flag raised during reset
        chk({62'd0, mce_irq, reset_req}, 64'd0, "R1 pulses low in reset");
        chk({63'd0, init_busy}, 64'd1, "R1 busy in reset");
        mdl_clear();
        rst = 1'b0;
        // R1: request and write presented during the walk must vanish
        inj_bank = 8'd0; inj_status = VAL | UC; inj_gstatus = 64'h4;
        inj_addr = 64'h1234; inj_misc = 64'h5; inj_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        inj_valid = 1'b0;
        reg_addr = AW'(A_GSTS); reg_wdata = 64'h4; reg_wr = 1'b1;
        n = 1;
        while (init_busy && n < 100) begin
            chk({62'd0, mce_irq, reset_req}, 64'd0, "R1 no pulse during walk");
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        reg_wr = 1'b0;
        chk(64'(n), 64'(NB), {tag, " R1 walk length"});
        chk({62'd0, mce_irq, reset_req}, 64'd0, "R1 no pulse after walk");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        logic [63:0] v;
        void'($urandom(32'd20240611));
        mdl_clear();

        // R2: unqualified family leaves every word zero
        do_reset(4'd5, 1'b1, 1'b1, "unqual");
        chk_word(A_CAP, 64'd0, "R2 cap unqualified");
        verify_all("R2 unqualified");
        // R3: bank count zero, every request ignored
        inject(0, VAL, 64'h0, 64'hAA, 64'hBB, "R3 count zero");

        // R2: missing feature also unqualified
        do_reset(4'd7, 1'b1, 1'b0, "nofeat");
        chk_word(A_CAP, 64'd0, "R2 cap no feature");

        // R2: qualified walk
        do_reset(4'd6, 1'b1, 1'b1, "qual");
        m_cap = 64'h104; m_gctl = ONES;
        for (int i = 0; i < NB; i++) m_ctl[i] = ONES;
        chk_word(A_CAP, 64'h104, "R2 cap default");
        verify_all("R2 qualified");

        // R4: status without valid bit ignored
        inject(0, UC | 64'h11, 64'h4, 64'h77, 64'h88, "R4 no valid");
        // R3: index at count and far above
        inject(4, VAL | UC, 64'h4, 64'h1, 64'h2, "R3 bank at count");
        inject(200, VAL, 64'h0, 64'h1, 64'h2, "R3 bank far");

        // R8: first uncorrected error, then the pulse drops
        inject(0, VAL | UC | 64'h101, 64'h4, 64'hDEAD, 64'h9, "R8 record");
        @(posedge clk); @(negedge clk);
        chk({63'd0, mce_irq}, 64'd0, "R8 single pulse");

        // R7: nested uncorrected while in progress
        inject(1, VAL | UC | 64'h2, 64'h4, 64'hBEEF, 64'h3, "R7 nested");
        @(posedge clk); @(negedge clk);
        chk({63'd0, reset_req}, 64'd0, "R7 single pulse");

        // R10: corrected onto pending uncorrected
        inject(0, VAL | 64'h55, 64'h0, 64'h1111, 64'h2222, "R10 mark only");

        // R11: clear in-progress through global status
        sw_write(A_GSTS, 64'h0);
        chk_word(A_GSTS, 64'h0, "R11 gstatus write");

        // R8: second uncorrected into valid bank gets overflow
        inject(0, VAL | UC | 64'h7, 64'h5, 64'h3333, 64'h4444, "R8 overflow");
        sw_write(A_GSTS, 64'h0);

        // R7: enable low
        mce_en = 1'b0;
        inject(2, VAL | UC, 64'h4, 64'h10, 64'h20, "R7 enable low");
        mce_en = 1'b1;

        // R9: corrected into empty bank, then onto corrected
        inject(3, VAL | 64'hC1, 64'h4, 64'h30, 64'h40, "R9 empty");
        inject(3, VAL | 64'hC2, 64'h4, 64'h31, 64'h41, "R9 overflow");

        // R6: bank control nearly all ones
        sw_write(4*2 + 0, ONES ^ 64'h1000);
        inject(2, VAL | UC, 64'h4, 64'h50, 64'h60, "R6 bank ctl");
        sw_write(4*2 + 0, ONES);

        // R5: global control not all ones while advertised
        sw_write(A_GCTL, ONES ^ 64'h8000_0000);
        inject(2, VAL | UC, 64'h4, 64'h70, 64'h80, "R5 global ctl");
        sw_write(A_GCTL, ONES);

        // R11: capability ignores writes; unmapped words read zero
        sw_write(A_CAP, 64'hFF);
        chk_word(A_CAP, 64'h104, "R11 cap read-only");
        for (int a = A_GSTS + 1; a < 32; a++) chk_word(a, 64'd0, "R11 unmapped");

        // R12: write collides with an ignored injection
        inj_bank = 8'd0; inj_status = 64'h0; inj_valid = 1'b1;
        reg_addr = AW'(4*3 + 3); reg_wdata = 64'hF00D; reg_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        inj_valid = 1'b0; reg_wr = 1'b0;
        chk_word(4*3 + 3, m_misc[3], "R12 write discarded");

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int op = int'($urandom % 10);
            if (op == 0) begin
                int bb = int'($urandom % NB);
                sw_write(4*bb, ($urandom % 4 == 0) ? {$urandom, $urandom} : ONES);
            end else if (op == 1) begin
                sw_write(A_GSTS, 64'h0);
            end else if (op == 2) begin
                sw_write(4*int'($urandom % NB) + 1, 64'h0);
            end else begin
                logic [63:0] s = {$urandom, $urandom};
                logic [63:0] g = {$urandom, $urandom};
                s[63] = ($urandom % 10) != 0;
                s[61] = $urandom % 2;
                g[2]  = $urandom % 2;
                mce_en = ($urandom % 8) != 0;
                inject(int'($urandom % 6), s, g, {$urandom, $urandom}, {$urandom, $urandom},
                       s[61] ? "R8 random uc" : "R9 random ce");
            end
        end
        mce_en = 1'b1;
        verify_all("R10 random final");
        rd(A_CAP, v);
        chk(v, 64'h104, "R11 cap final");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule